// File: doc/BRIEF.md
# Vectored Interrupt Controller Unit

This block decides, every machine cycle, whether the attached 8-bit core should be diverted into an interrupt service routine, and to which address. It looks at the pending flags of up to sixteen source slots as they stand in that cycle. Each slot owns a fixed 8-byte entry point at address `8*slot + 3`. Eleven slots are populated: external pin 0, timer 0, external pin 1, timer 1, serial port, brownout, edge detect, watchdog, ADC, PWM underflow and PWM brake. A global enable, per-slot enables and a per-slot priority bit select one slot. Two priority levels are supported, and within a level the lower slot number wins.

The call request is a valid/ready handshake. `call_valid` with `call_vector` offers a call. The core takes it by raising `call_ready`, and then performs the long call itself, pushing only the program counter. Back-pressure does not hold the offer: requests are re-evaluated every cycle from the live flags, and none is latched. While `call_ready` is low, the offered vector may change or disappear, and a flag that falls before it is accepted is simply lost. On acceptance the block marks the accepted level as in service. One cycle later it pulses a hardware clear for the flag, but only for timer overflow slots, and for external pin slots that are configured as edge-triggered. A separate return-from-interrupt pulse from the core ends the innermost active service. An ordinary subroutine return never reaches this block.

Top module: `vic_unit`

## Requirements
- R1: While `call_valid` is high, `call_vector` equals 8*slot+3 for the chosen slot (slot 0 gives 0x0003, slot 14 gives 0x0073).
- R2: A slot can request only when its flag, its enable bit and `glob_en` are all high and the slot is populated. Slots 6, 8, 9, 12 and 15 are unpopulated and never request.
- R3: Among requesting slots, any slot with its `src_hi` bit set beats every slot with it clear. Within the same level, the lowest slot number wins.
- R4: While `svc_lo` is set and `svc_hi` is clear, only slots with `src_hi` set may request. While `svc_hi` is set, no request is made.
- R5: `svc_hi` and `svc_lo` stay set until a `reti` pulse. A `reti` clears `svc_hi` if it is set, and otherwise clears `svc_lo`.
- R6: `call_valid` is low in any cycle in which `reti` is high.
- R7: One cycle after a handshake (`call_valid` and `call_ready` high at a clock edge), `flag_clr` is one-hot on the accepted slot when that slot is 1 or 3 (timers), or is 0 or 2 (external pins) with its `edge_mode` bit high. Otherwise `flag_clr` stays zero. It is zero in every cycle that does not follow a handshake.
- R8: A handshake sets `svc_hi` if the accepted slot has `src_hi` set, and sets `svc_lo` otherwise, from the next cycle on.
- R9: After reset, `svc_hi`, `svc_lo` and `flag_clr` are all zero.
- R10: No request is remembered. A flag that was active but was not accepted, and has gone low by the time the gating allows it, produces no call. While `call_ready` is low, `call_vector` follows the current flags cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag | input | 16 | Pending flag per slot, sampled live |
| src_en | input | 16 | Per-slot enable |
| src_hi | input | 16 | Per-slot priority level (1 = high) |
| edge_mode | input | 16 | Per-slot edge-trigger mode (used on slots 0 and 2) |
| glob_en | input | 1 | Global interrupt enable |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| call_ready | input | 1 | Core accepts the offered call |
| call_valid | output | 1 | Call request offered this cycle |
| call_vector | output | 16 | Entry address of the offered call |
| flag_clr | output | 16 | One-cycle hardware clear per slot |
| svc_hi | output | 1 | High-level service in progress |
| svc_lo | output | 1 | Low-level service in progress |

## Verification
The properties assume that the core issues `reti` only while some service is in progress. They also assume that `call_ready` is meaningful only while a call is offered, so that a handshake is the only route into service. The stimulus keeps to these limits. It pulses `reti` once per nested entry and once in idle, which is harmless because a return then has nothing to clear, and it raises `call_ready` only in cycles in which it expects an offer. Flags, enables and priority bits are changed only on the falling edge. This lets the combinational offer settle before the bench samples it and before the next rising edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SLOT_BYTES = 8;
  localparam int ENTRY_OFS  = 3;

  function automatic int slot_entry(input int slot);
    return slot * SLOT_BYTES + ENTRY_OFS;
  endfunction
endpackage

// File: rtl/vic_req_gate.sv
module vic_req_gate #(
  parameter int NSRC = 16,
  parameter logic [NSRC-1:0] USED_MASK = '1
) (
  input  logic [NSRC-1:0] flag,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic            glob_en,
  input  logic            reti,
  input  logic            busy_hi,
  input  logic            busy_lo,
  output logic [NSRC-1:0] req_hi,
  output logic [NSRC-1:0] req_lo
);
  logic [NSRC-1:0] live;

  always_comb begin
    live   = flag & src_en & USED_MASK & {NSRC{glob_en && !reti && !busy_hi}};
    req_hi = live & src_hi;
    req_lo = live & ~src_hi & {NSRC{!busy_lo}};
  end
endmodule

// File: rtl/vic_first_pick.sv
module vic_first_pick #(
  parameter int NSRC  = 16,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_svc_track.sv
module vic_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic svc_hi,
  output logic svc_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) svc_hi <= 1'b1;
      else         svc_lo <= 1'b1;
    end else if (reti) begin
      if (svc_hi) svc_hi <= 1'b0;
      else        svc_lo <= 1'b0;
    end
  end
endmodule

// File: rtl/vic_clr_gen.sv
module vic_clr_gen #(
  parameter int NSRC = 16,
  parameter logic [NSRC-1:0] ALWAYS_CLR = '0,
  parameter logic [NSRC-1:0] EDGE_CLR   = '0,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  input  logic [NSRC-1:0]  edge_mode,
  output logic [NSRC-1:0]  flag_clr
);
  logic [NSRC-1:0] sel;
  logic [NSRC-1:0] clr_ok;

  always_comb begin
    sel    = NSRC'(1) << take_idx;
    clr_ok = ALWAYS_CLR | (EDGE_CLR & edge_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_clr <= '0;
    else if (take) flag_clr <= sel & clr_ok;
    else           flag_clr <= '0;
  end
endmodule

// File: rtl/vic_unit.sv
module vic_unit #(
  parameter int NSRC  = 16,
  parameter int VEC_W = 16,
  parameter logic [NSRC-1:0] USED_MASK  = 16'h6CBF,
  parameter logic [NSRC-1:0] ALWAYS_CLR = 16'h000A,
  parameter logic [NSRC-1:0] EDGE_CLR   = 16'h0005
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  flag,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic [NSRC-1:0]  edge_mode,
  input  logic             glob_en,
  input  logic             reti,
  input  logic             call_ready,
  output logic             call_valid,
  output logic [VEC_W-1:0] call_vector,
  output logic [NSRC-1:0]  flag_clr,
  output logic             svc_hi,
  output logic             svc_lo
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  req_hi, req_lo;
  logic             hi_found, lo_found;
  logic [IDX_W-1:0] hi_idx, lo_idx, win_idx;
  logic             take;

  vic_req_gate #(.NSRC(NSRC), .USED_MASK(USED_MASK)) u_gate (
    .flag(flag), .src_en(src_en), .src_hi(src_hi), .glob_en(glob_en),
    .reti(reti), .busy_hi(svc_hi), .busy_lo(svc_lo),
    .req_hi(req_hi), .req_lo(req_lo)
  );

  vic_first_pick #(.NSRC(NSRC)) u_pick_hi (
    .req(req_hi), .found(hi_found), .idx(hi_idx)
  );

  vic_first_pick #(.NSRC(NSRC)) u_pick_lo (
    .req(req_lo), .found(lo_found), .idx(lo_idx)
  );

  always_comb begin
    win_idx     = hi_found ? hi_idx : lo_idx;
    call_valid  = hi_found | lo_found;
    call_vector = VEC_W'(vic_pkg::slot_entry(int'(win_idx)));
    take        = call_valid & call_ready;
  end

  vic_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(hi_found),
    .reti(reti), .svc_hi(svc_hi), .svc_lo(svc_lo)
  );

  vic_clr_gen #(.NSRC(NSRC), .ALWAYS_CLR(ALWAYS_CLR), .EDGE_CLR(EDGE_CLR)) u_clr (
    .clk(clk), .rst_n(rst_n), .take(take), .take_idx(win_idx),
    .edge_mode(edge_mode), .flag_clr(flag_clr)
  );
endmodule

// File: rtl/vic_unit_chk.sv
module vic_unit_chk #(
  parameter int NSRC  = 16,
  parameter int VEC_W = 16,
  parameter logic [NSRC-1:0] ALWAYS_CLR = 16'h000A,
  parameter logic [NSRC-1:0] EDGE_CLR   = 16'h0005
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  flag,
  input logic [NSRC-1:0]  src_en,
  input logic             glob_en,
  input logic             reti,
  input logic             call_ready,
  input logic             call_valid,
  input logic [VEC_W-1:0] call_vector,
  input logic [NSRC-1:0]  flag_clr,
  input logic             svc_hi,
  input logic             svc_lo
);
  localparam int IDX_W = $clog2(NSRC);

  logic [IDX_W-1:0] slot_of_vec;
  assign slot_of_vec = call_vector[IDX_W+2:3];

  p_vec_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> (call_vector[2:0] == 3'd3) && flag[slot_of_vec] && src_en[slot_of_vec]);

  p_glob_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> glob_en);

  p_hi_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi |-> !call_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_hi && !reti) |=> svc_hi);

  p_reti_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reti |-> !call_valid);

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr) && ((flag_clr & ~(ALWAYS_CLR | EDGE_CLR)) == '0));

  p_clr_after_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && call_ready) |=> ($countones(flag_clr) <= 1));

  p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && call_ready) |=> (svc_hi || svc_lo));
endmodule

bind vic_unit vic_unit_chk #(
  .NSRC(NSRC), .VEC_W(VEC_W), .ALWAYS_CLR(ALWAYS_CLR), .EDGE_CLR(EDGE_CLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flag(flag), .src_en(src_en), .glob_en(glob_en),
  .reti(reti), .call_ready(call_ready), .call_valid(call_valid),
  .call_vector(call_vector), .flag_clr(flag_clr), .svc_hi(svc_hi), .svc_lo(svc_lo)
);

// File: tb/vic_unit_test.sv
module vic_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] flag = '0, src_en = '0, src_hi = '0, edge_mode = '0;
  logic        glob_en = 1'b0, reti = 1'b0, call_ready = 1'b0;
  logic        call_valid;
  logic [15:0] call_vector;
  logic [15:0] flag_clr;
  logic        svc_hi, svc_lo;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_unit uut (
    .clk(clk), .rst_n(rst_n), .flag(flag), .src_en(src_en), .src_hi(src_hi),
    .edge_mode(edge_mode), .glob_en(glob_en), .reti(reti), .call_ready(call_ready),
    .call_valid(call_valid), .call_vector(call_vector), .flag_clr(flag_clr),
    .svc_hi(svc_hi), .svc_lo(svc_lo)
  );

  function automatic bit populated(input int s);
    return !(s == 6 || s == 8 || s == 9 || s == 12 || s == 15);
  endfunction

  function automatic int winner(input logic [15:0] req, input logic [15:0] hi);
    int r = -1;
    for (int i = 15; i >= 0; i--) if (req[i] && hi[i] && populated(i)) r = i;
    if (r < 0) for (int i = 15; i >= 0; i--) if (req[i] && populated(i)) r = i;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 svc_hi", int'(svc_hi), 0);
    chk("R9 svc_lo", int'(svc_lo), 0);
    chk("R9 flag_clr", int'(flag_clr), 0);
    rst_n = 1'b1;
    step();
    chk("R9 svc after release", int'({svc_hi, svc_lo}), 0);

    // R1 / R2: single slot sweep over enables
    for (int i = 0; i < 16; i++) begin
      for (int g = 0; g < 2; g++) begin
        for (int e = 0; e < 2; e++) begin
          flag    = 16'(1) << i;
          src_en  = e ? (16'(1) << i) : 16'h0;
          glob_en = g[0];
          #1;
          chk("R2 gating", int'(call_valid), (g == 1 && e == 1 && populated(i)) ? 1 : 0);
          if (call_valid) chk("R1 vector", int'(call_vector), 8 * i + 3);
        end
      end
    end

    // R3: every ordered pair under all priority combinations
    src_en = 16'hFFFF;
    glob_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        if (i != j) begin
          for (int p = 0; p < 4; p++) begin
            int w;
            flag   = (16'(1) << i) | (16'(1) << j);
            src_hi = (p[0] ? (16'(1) << i) : 16'h0) | (p[1] ? (16'(1) << j) : 16'h0);
            #1;
            w = winner(flag, src_hi);
            chk("R3 valid", int'(call_valid), (w >= 0) ? 1 : 0);
            if (w >= 0) chk("R3 winner", int'(call_vector), 8 * w + 3);
          end
        end
      end
    end
    src_hi = '0;
    flag = '0;
    #1;

    // R7 / R8 / R5: clear strobes for each populated slot, both trigger modes
    for (int i = 0; i < 16; i++) begin
      if (populated(i)) begin
        for (int m = 0; m < 2; m++) begin
          int ec;
          edge_mode  = m ? 16'hFFFF : 16'h0;
          flag       = 16'(1) << i;
          call_ready = 1'b1;
          step();
          call_ready = 1'b0;
          flag       = '0;
          #1;
          ec = (i == 1 || i == 3 || ((i == 0 || i == 2) && m == 1)) ? (1 << i) : 0;
          chk("R7 clear strobe", int'(flag_clr), ec);
          chk("R8 svc_lo set", int'(svc_lo), 1);
          reti = 1'b1;
          step();
          reti = 1'b0;
          #1;
          chk("R7 strobe one cycle", int'(flag_clr), 0);
          chk("R5 reti ends", int'(svc_lo), 0);
        end
      end
    end
    edge_mode = '0;

    // R4 / R5 / R8: nesting
    flag = 16'h0020;
    call_ready = 1'b1;
    step();
    call_ready = 1'b0;
    flag = 16'h00A0;
    #1;
    chk("R8 low entry", int'({svc_hi, svc_lo}), 1);
    chk("R4 low blocked in low", int'(call_valid), 0);
    src_hi = 16'h0800;
    flag = 16'h08A0;
    #1;
    chk("R4 high preempts", int'(call_valid), 1);
    chk("R4 high vector", int'(call_vector), 16'h005B);
    call_ready = 1'b1;
    step();
    call_ready = 1'b0;
    src_hi = 16'h0801;
    flag = 16'h08A1;
    #1;
    chk("R8 high entry", int'({svc_hi, svc_lo}), 3);
    chk("R4 high blocked in high", int'(call_valid), 0);
    step();
    step();
    chk("R5 held without reti", int'({svc_hi, svc_lo}), 3);
    flag = '0;
    reti = 1'b1;
    step();
    reti = 1'b0;
    #1;
    chk("R5 reti clears high first", int'({svc_hi, svc_lo}), 1);
    step();
    chk("R5 low held", int'(svc_lo), 1);
    reti = 1'b1;
    step();
    reti = 1'b0;
    #1;
    chk("R5 reti clears low", int'({svc_hi, svc_lo}), 0);
    src_hi = '0;

    // R6: no offer during a reti cycle
    flag = 16'h0010;
    reti = 1'b1;
    #1;
    chk("R6 reti cycle", int'(call_valid), 0);
    step();
    reti = 1'b0;
    #1;
    chk("R6 after reti", int'(call_valid), 1);

    // R10: denied request dropped; vector tracks flags under back-pressure
    glob_en = 1'b0;
    flag = 16'h0010;
    step();
    step();
    flag = '0;
    step();
    glob_en = 1'b1;
    #1;
    chk("R10 dropped", int'(call_valid), 0);
    flag = 16'h4000;
    #1;
    chk("R10 follow a", int'(call_vector), 16'h0073);
    step();
    flag = 16'h4080;
    #1;
    chk("R10 follow b", int'(call_vector), 16'h003B);
    step();
    flag = 16'h0000;
    #1;
    chk("R10 offer gone", int'(call_valid), 0);
    chk("R10 no service taken", int'({svc_hi, svc_lo}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule